// File: doc/BRIEF.md
# Decimal-Scaled Real Multiplier

This block multiplies two unsigned decimal real numbers. Each operand arrives as an integer part, a field that holds its digits after the decimal point, and a count of those digits. The block scales every operand to an exact integer by multiplying its integer part by ten once per fractional digit and then adding the fractional field. It multiplies the two scaled integers. It then divides the product by ten raised to the combined digit count, which gives the integer part and the fractional digits of the result.

An operand pair is accepted through a valid/ready handshake. Only one operation is in flight at a time. Scaling by ten is done with shifts and adds, one decade per cycle. The division is a restoring divider that produces one quotient bit per cycle. A single-cycle output strobe marks the moment when all result fields are valid. As an example, 3.14 × 4.15 is presented as (3, 14, 2) and (4, 15, 2). The block returns a scaled product of 130310 with 4 digits, split into 13 and 310.

Top module: `dec_real_mul`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid_o` is 0, `in_ready_o` is 1, and every result output reads 0.
- R2: `product_o` equals (a_int·10^a_digits + a_frac) × (b_int·10^b_digits + b_frac), computed exactly with no truncation.
- R3: `digits_o` equals a_digits + b_digits, in the range 0 to 6.
- R4: `int_part_o` equals `product_o` divided by 10^`digits_o`, rounded down. `frac_part_o` is the remainder of that division, so `int_part_o`·10^`digits_o` + `frac_part_o` = `product_o`.
- R5: `out_valid_o` is high for exactly one cycle. It rises a_digits + b_digits + 37 rising edges after the edge that accepts the operands, where accept means `in_valid_i` and `in_ready_o` are both high.
- R6: `in_ready_o` is low from the accepting edge until one cycle after the `out_valid_o` pulse. While it is low, `in_valid_i` and the operand inputs have no effect on the result in flight.
- R7: 3.14 × 4.15 yields `product_o`=130310, `digits_o`=4, `int_part_o`=13 and `frac_part_o`=310.
- R8: With both digit counts at 0, the result is a plain integer product, with `int_part_o` equal to `product_o` and `frac_part_o` equal to 0.
- R9: The largest operands, 255.999 × 255.999, give 65535488001, split into 65535 and 488001, with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand pair offered |
| in_ready_o | output | 1 | Block idle, can accept operands |
| a_int_i | input | 8 | Integer part of operand A |
| a_frac_i | input | 10 | Fractional digits of A, below 10^a_digits |
| a_digits_i | input | 2 | Number of fractional digits of A (0–3) |
| b_int_i | input | 8 | Integer part of operand B |
| b_frac_i | input | 10 | Fractional digits of B, below 10^b_digits |
| b_digits_i | input | 2 | Number of fractional digits of B (0–3) |
| out_valid_o | output | 1 | Single-cycle result strobe |
| product_o | output | 36 | Scaled integer product |
| digits_o | output | 3 | Fractional digit count of the product |
| int_part_o | output | 36 | Integer part of the result |
| frac_part_o | output | 20 | Fractional digits of the result |

## Verification
A result is due a_digits + b_digits + 37 rising edges after its accepting edge. That count covers the decade shifts, one cycle to form the product and start the divider, and 36 divider steps. The driver records the cycle number of the accepting edge with each expected item. The monitor samples on the falling edge, compares every field against values computed with wide integer arithmetic, and checks the elapsed cycle count against the formula. It also checks that `in_ready_o` stays low through the pulse and returns one cycle later.

// File: rtl/dec_mul_pkg.sv
package dec_mul_pkg;

  function automatic longint unsigned pow10(input int unsigned n);
    longint unsigned r;
    r = 1;
    for (int unsigned i = 0; i < n; i++) r = r * 10;
    return r;
  endfunction

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCALE = 2'd1,
    ST_DIV   = 2'd2
  } mul_state_e;

endpackage

// File: rtl/dec_scaler.sv
// Multiplies a loaded value by ten once per cycle, count_i times.
module dec_scaler #(
  parameter int unsigned W  = 18,
  parameter int unsigned CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [W-1:0]  base_i,
  input  logic [CW-1:0] count_i,
  output logic [W-1:0]  value_o,
  output logic          done_o
);
  logic [W-1:0]  val_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      val_q <= base_i;
      cnt_q <= count_i;
    end else if (cnt_q != '0) begin
      val_q <= (val_q << 3) + (val_q << 1);
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign value_o = val_q;
  assign done_o  = (cnt_q == '0);

  assert_done_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !load_i) |=> (done_o && $stable(value_o)));

  assert_count_drops_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/dec_divider.sv
// Restoring divider, one quotient bit per cycle, DW steps.
module dec_divider #(
  parameter int unsigned DW = 36,
  parameter int unsigned VW = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [VW-1:0] divisor_i,
  output logic          valid_o,
  output logic [DW-1:0] quotient_o,
  output logic [VW-1:0] remainder_o
);
  localparam int unsigned CNT_W = $clog2(DW + 1);

  logic [DW-1:0]    dvd_q;
  logic [VW-1:0]    rem_q, dsr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, valid_q;
  logic [VW:0]      rem_sh, diff;

  assign rem_sh = {rem_q, dvd_q[DW-1]};
  assign diff   = rem_sh - {1'b0, dsr_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvd_q   <= '0;
      rem_q   <= '0;
      dsr_q   <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (start_i) begin
        dvd_q  <= dividend_i;
        dsr_q  <= divisor_i;
        rem_q  <= '0;
        cnt_q  <= CNT_W'(DW);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        // restore when the trial subtraction goes negative
        if (diff[VW]) begin
          rem_q <= rem_sh[VW-1:0];
          dvd_q <= {dvd_q[DW-2:0], 1'b0};
        end else begin
          rem_q <= diff[VW-1:0];
          dvd_q <= {dvd_q[DW-2:0], 1'b1};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q  <= 1'b0;
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign valid_o     = valid_q;
  assign quotient_o  = dvd_q;
  assign remainder_o = rem_q;

  assert_rem_below_divisor_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (remainder_o < dsr_q));

  assert_no_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !start_i);
endmodule

// File: rtl/dec_real_mul.sv
module dec_real_mul
  import dec_mul_pkg::*;
#(
  parameter int unsigned MAX_DIGITS = 3,
  parameter int unsigned INT_W      = 8,
  localparam int unsigned DIG_W  = $clog2(MAX_DIGITS + 1),
  localparam int unsigned FRAC_W = $clog2(pow10(MAX_DIGITS)),
  localparam int unsigned SUM_W  = $clog2(2 * MAX_DIGITS + 1),
  localparam int unsigned SC_W   = $clog2((longint'(1) << INT_W) * pow10(MAX_DIGITS)),
  localparam int unsigned PROD_W = 2 * SC_W,
  localparam int unsigned POW_W  = $clog2(pow10(2 * MAX_DIGITS) + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [INT_W-1:0]  a_int_i,
  input  logic [FRAC_W-1:0] a_frac_i,
  input  logic [DIG_W-1:0]  a_digits_i,
  input  logic [INT_W-1:0]  b_int_i,
  input  logic [FRAC_W-1:0] b_frac_i,
  input  logic [DIG_W-1:0]  b_digits_i,
  output logic              out_valid_o,
  output logic [PROD_W-1:0] product_o,
  output logic [SUM_W-1:0]  digits_o,
  output logic [PROD_W-1:0] int_part_o,
  output logic [POW_W-1:0]  frac_part_o
);
  mul_state_e        state_q;
  logic              accept, load, all_done, div_start, div_valid;
  logic [FRAC_W-1:0] fa_q, fb_q;
  logic [SUM_W-1:0]  dsum, digits_q;
  logic [SC_W-1:0]   val_a, val_b, scaled_a, scaled_b;
  logic [POW_W-1:0]  pow_val, pow_q;
  logic              done_a, done_b, done_p;
  logic [PROD_W-1:0] prod_raw, prod_q;

  assign in_ready_o = (state_q == ST_IDLE);
  assign accept     = in_valid_i && in_ready_o;
  assign load       = accept;
  assign dsum       = SUM_W'(a_digits_i) + SUM_W'(b_digits_i);
  assign all_done   = done_a && done_b && done_p;
  assign div_start  = (state_q == ST_SCALE) && all_done;

  dec_scaler #(.W(SC_W), .CW(DIG_W)) i_scale_a (
    .clk_i, .rst_ni, .load_i(load), .base_i(SC_W'(a_int_i)),
    .count_i(a_digits_i), .value_o(val_a), .done_o(done_a));

  dec_scaler #(.W(SC_W), .CW(DIG_W)) i_scale_b (
    .clk_i, .rst_ni, .load_i(load), .base_i(SC_W'(b_int_i)),
    .count_i(b_digits_i), .value_o(val_b), .done_o(done_b));

  dec_scaler #(.W(POW_W), .CW(SUM_W)) i_scale_pow (
    .clk_i, .rst_ni, .load_i(load), .base_i(POW_W'(1)),
    .count_i(dsum), .value_o(pow_val), .done_o(done_p));

  assign scaled_a = val_a + SC_W'(fa_q);
  assign scaled_b = val_b + SC_W'(fb_q);
  assign prod_raw = PROD_W'(scaled_a) * PROD_W'(scaled_b);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      fa_q     <= '0;
      fb_q     <= '0;
      digits_q <= '0;
      prod_q   <= '0;
      pow_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          fa_q     <= a_frac_i;
          fb_q     <= b_frac_i;
          digits_q <= dsum;
          state_q  <= ST_SCALE;
        end
        ST_SCALE: if (all_done) begin
          prod_q  <= prod_raw;
          pow_q   <= pow_val;
          state_q <= ST_DIV;
        end
        ST_DIV: if (div_valid) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  dec_divider #(.DW(PROD_W), .VW(POW_W)) i_div (
    .clk_i, .rst_ni, .start_i(div_start), .dividend_i(prod_raw),
    .divisor_i(pow_val), .valid_o(div_valid), .quotient_o(int_part_o),
    .remainder_o(frac_part_o));

  assign out_valid_o = div_valid;
  assign product_o   = prod_q;
  assign digits_o    = digits_q;

  assert_split_consistent_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ((int_part_o * PROD_W'(pow_q)) + PROD_W'(frac_part_o) == product_o));

  assert_valid_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);

  assert_busy_during_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);

  assert_ready_after_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> in_ready_o);

  assert_digit_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (digits_o <= SUM_W'(2 * MAX_DIGITS)));
endmodule

// File: tb/test_dec_real_mul.sv
module test_dec_real_mul;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [7:0]  a_int_i = '0, b_int_i = '0;
  logic [9:0]  a_frac_i = '0, b_frac_i = '0;
  logic [1:0]  a_digits_i = '0, b_digits_i = '0;
  logic        out_valid_o;
  logic [35:0] product_o, int_part_o;
  logic [2:0]  digits_o;
  logic [19:0] frac_part_o;

  typedef struct {
    longint unsigned prod;
    longint unsigned dig;
    longint unsigned ip;
    longint unsigned fp;
    longint unsigned lat;
    longint unsigned acc;
    string           tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0;
  longint unsigned cyc = 0;

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  dec_real_mul i_dec_real_mul (.*);

  function automatic longint unsigned p10(input int n);
    longint unsigned r = 1;
    for (int i = 0; i < n; i++) r = r * 10;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input longint unsigned act,
                     input longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input int ai, input int af, input int ad,
                      input int bi, input int bf, input int bd, input string tag);
    exp_t e;
    longint unsigned sa, sb;
    sa = longint'(ai) * p10(ad) + longint'(af);
    sb = longint'(bi) * p10(bd) + longint'(bf);
    e.prod = sa * sb;
    e.dig  = longint'(ad + bd);
    e.ip   = e.prod / p10(ad + bd);
    e.fp   = e.prod % p10(ad + bd);
    e.lat  = longint'(ad + bd + 37);
    e.tag  = tag;
    @(negedge clk_i);
    while (!in_ready_o) @(negedge clk_i);
    a_int_i = 8'(ai); a_frac_i = 10'(af); a_digits_i = 2'(ad);
    b_int_i = 8'(bi); b_frac_i = 10'(bf); b_digits_i = 2'(bd);
    in_valid_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    e.acc = cyc;
    q.push_back(e);
    in_valid_i = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk_i);
    @(negedge clk_i);
    @(negedge clk_i);
  endtask

  // monitor: pop and compare on each result strobe
  always @(negedge clk_i) begin
    if (rst_ni && out_valid_o) begin
      if (q.size() == 0) begin
        chk(1'b0, "R5 unexpected strobe", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(product_o == 36'(e.prod), {"R2 product ", e.tag}, product_o, e.prod);
        chk(digits_o == 3'(e.dig), {"R3 digits ", e.tag}, digits_o, e.dig);
        chk(int_part_o == 36'(e.ip), {"R4 int ", e.tag}, int_part_o, e.ip);
        chk(frac_part_o == 20'(e.fp), {"R4 frac ", e.tag}, frac_part_o, e.fp);
        chk(cyc - e.acc == e.lat, {"R5 latency ", e.tag}, cyc - e.acc, e.lat);
        chk(!in_ready_o, "R6 ready low at strobe", in_ready_o, 0);
      end
    end
  end

  // watchdog
  initial begin
    while (cyc < 100000) @(posedge clk_i);
    chk(1'b0, "watchdog", cyc, 100000);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!out_valid_o, "R1 valid in reset", out_valid_o, 0);
    chk(in_ready_o, "R1 ready in reset", in_ready_o, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!out_valid_o && in_ready_o, "R1 after release", {out_valid_o, in_ready_o}, 1);
    chk(product_o == 0 && int_part_o == 0 && frac_part_o == 0 && digits_o == 0,
        "R1 result zero", product_o, 0);

    send(3, 14, 2, 4, 15, 2, "R7");
    drain();
    send(12, 0, 0, 21, 0, 0, "R8");
    drain();
    chk(frac_part_o == 0 && int_part_o == product_o, "R8 integer split", frac_part_o, 0);
    send(255, 999, 3, 255, 999, 3, "R9");
    drain();
    send(7, 5, 1, 0, 0, 0, "mixed");
    drain();

    // R6: input changes while busy have no effect
    send(1, 25, 2, 8, 3, 1, "R6");
    @(negedge clk_i);
    chk(!in_ready_o, "R6 ready low when busy", in_ready_o, 0);
    a_int_i = 8'd200; b_int_i = 8'd99; a_frac_i = 10'd7; a_digits_i = 2'd3;
    in_valid_i = 1'b1;
    repeat (5) @(negedge clk_i);
    in_valid_i = 1'b0;
    while (!out_valid_o) @(negedge clk_i);
    @(negedge clk_i);
    chk(in_ready_o, "R6 ready back after strobe", in_ready_o, 1);
    drain();

    for (int k = 0; k < 24; k++) begin
      int ad, bd;
      ad = int'($urandom % 4);
      bd = int'($urandom % 4);
      send(int'($urandom % 256), int'($urandom % p10(ad)), ad,
           int'($urandom % 256), int'($urandom % p10(bd)), bd, "R2 random");
      drain();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule